// File: doc/BRIEF.md
# Switch Change Interrupt Controller

This block watches a vector of already synchronized switch inputs and asks for service through an active-low interrupt whenever an enabled input changes state. The interrupt pin is open-drain with a pull-up, so the block produces only a pull-down request: high means "drive the pin low", low means "release it".

A companion serial interface supplies one-cycle strobes for the chip select falling and rising edges. On the falling edge the block captures the current interrupt level for the host to read, and it takes a fresh snapshot of the switches as the new reference. On the rising edge it releases the interrupt, unless an enabled switch changed while chip select was low. That exception makes sure no event can slip between the read and the clear. While the mode input selects sleep, detection stops and the interrupt stays released.

Top module: `swchg_irq`

## Requirements
- R1: While `rst_n` is low on a clock edge, `irq_pull_low` and `irq_snap` become 0 after that edge.
- R2: The reference vector takes the value of `sw_in` present during reset, so inputs that are held steady across reset release raise no interrupt.
- R3: In normal mode (`sleep`=0), when bit i of `sw_in` differs from its reference and `en_mask[i]`=1, `irq_pull_low` is 1 after the next clock edge.
- R4: A change on an input whose `en_mask` bit is 0 never sets `irq_pull_low`.
- R5: Once set, `irq_pull_low` stays 1 until a `cs_rise` strobe or sleep mode, even if the switch returns to its old state.
- R6: On a `cs_fall` strobe, `irq_snap` takes the interrupt level, including any change seen in that same cycle, and holds it until the next `cs_fall`. The reference is reloaded from `sw_in` at the same edge.
- R7: On a `cs_rise` strobe, with no enabled change since the last `cs_fall`, `irq_pull_low` becomes 0 after that edge.
- R8: If an enabled input changed between `cs_fall` and `cs_rise`, `irq_pull_low` stays 1 through the `cs_rise`. The next complete transfer with no new change releases it.
- R9: A masked input that changes while chip select is low does not block the release on `cs_rise`.
- R10: With `sleep`=1, `irq_pull_low` is 0 after the next edge and stays 0. The reference follows `sw_in` during sleep, so switches that moved while asleep raise no interrupt on return to normal mode.
- R11: An enabled change in the same cycle as a `cs_fall` is not lost. It appears in `irq_snap`, and `irq_pull_low` is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sw_in | input | NSW | Synchronized switch states, 1 = closed |
| en_mask | input | NSW | Per-input interrupt enable, 1 = enabled |
| sleep | input | 1 | Mode select: 1 = sleep, 0 = normal |
| cs_fall | input | 1 | One-cycle strobe marking the chip select falling edge |
| cs_rise | input | 1 | One-cycle strobe marking the chip select rising edge |
| irq_pull_low | output | 1 | Pull-down request for the open-drain interrupt pin |
| irq_snap | output | 1 | Interrupt level captured at the last chip select fall |

## Verification
Every result is due exactly one clock edge after its stimulus. A switch change, a strobe or a mode change that is driven before an edge shows up on `irq_pull_low` or `irq_snap` just after that edge. The bench drives inputs on the falling clock edge, lets exactly one rising edge pass, and samples on the next falling edge, so each check reads the settled state of that single edge. Persistence checks (R5, R10) add further single-edge steps and check after each one.

// File: rtl/swchg_irq.sv
module swchg_irq #(
  parameter int NSW = 22
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NSW-1:0] sw_in,
  input  logic [NSW-1:0] en_mask,
  input  logic           sleep,
  input  logic           cs_fall,
  input  logic           cs_rise,
  output logic           irq_pull_low,
  output logic           irq_snap
);

  logic [NSW-1:0] ref_q;
  logic pend_q, hold_q, cs_low_q, snap_q;
  logic hit;

  assign hit = |((sw_in ^ ref_q) & en_mask);
  assign irq_pull_low = pend_q;
  assign irq_snap = snap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q    <= sw_in;
      pend_q   <= 1'b0;
      hold_q   <= 1'b0;
      cs_low_q <= 1'b0;
      snap_q   <= 1'b0;
    end else if (sleep) begin
      ref_q  <= sw_in;
      pend_q <= 1'b0;
      hold_q <= 1'b0;
      if (cs_fall) cs_low_q <= 1'b1;
      else if (cs_rise) cs_low_q <= 1'b0;
    end else if (cs_fall) begin
      ref_q    <= sw_in;
      snap_q   <= pend_q | hit;
      pend_q   <= pend_q | hit;
      hold_q   <= 1'b0;
      cs_low_q <= 1'b1;
    end else if (cs_rise) begin
      pend_q   <= hold_q | hit;
      hold_q   <= 1'b0;
      cs_low_q <= 1'b0;
    end else begin
      pend_q <= pend_q | hit;
      if (cs_low_q && hit) hold_q <= 1'b1;
    end
  end

  // R10
  sleep_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !irq_pull_low);

  // R3
  rise_needs_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pull_low) |-> $past(!sleep));

  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull_low && !cs_rise && !sleep |=> irq_pull_low);

  // R6
  snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall && !sleep && irq_pull_low |=> irq_snap);

  // R8
  hold_through_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && !cs_fall && !sleep && hold_q |=> irq_pull_low);

  // R6
  snap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall |=> $stable(irq_snap));

endmodule

// File: tb/test_swchg_irq.sv
module test_swchg_irq;
  localparam int NSW = 22;
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSW-1:0] sw_in = '0;
  logic [NSW-1:0] en_mask = '1;
  logic sleep = 1'b0, cs_fall = 1'b0, cs_rise = 1'b0;
  logic irq_pull_low, irq_snap;
  int total = 0, bad = 0;
  bit done = 1'b0;

  swchg_irq #(.NSW(NSW)) i_swchg_irq (
    .clk(clk), .rst_n(rst_n), .sw_in(sw_in), .en_mask(en_mask),
    .sleep(sleep), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .irq_pull_low(irq_pull_low), .irq_snap(irq_snap));

  always #(TCLK/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cs_fall = 1'b0;
    cs_rise = 1'b0;
  endtask

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic xfer_clear();
    cs_fall = 1'b1; step();
    cs_rise = 1'b1; step();
  endtask

  initial begin
    #(TCLK * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    sw_in = 22'h2A5C3F;
    step(); step();
    chk("R1 irq", irq_pull_low, 1'b0);
    chk("R1 snap", irq_snap, 1'b0);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R2 steady after reset", irq_pull_low, 1'b0);

    // R3 / R4 sweep: every bit, enabled and masked
    for (int i = 0; i < NSW; i++) begin
      for (int m = 0; m < 2; m++) begin
        en_mask = m ? '1 : ~(NSW'(1) << i);
        sw_in[i] = ~sw_in[i];
        step();
        chk(m ? "R3 enabled change" : "R4 masked change", irq_pull_low, m[0]);
        xfer_clear();
        chk("R7 release", irq_pull_low, 1'b0);
      end
    end
    en_mask = '1;

    // R5
    sw_in[3] = ~sw_in[3]; step();
    sw_in[3] = ~sw_in[3];
    for (int k = 0; k < 3; k++) begin step(); chk("R5 sticky", irq_pull_low, 1'b1); end
    // R6
    cs_fall = 1'b1; step();
    chk("R6 snap set", irq_snap, 1'b1);
    chk("R6 irq held while low", irq_pull_low, 1'b1);
    cs_rise = 1'b1; step();
    chk("R7 release", irq_pull_low, 1'b0);
    chk("R6 snap holds", irq_snap, 1'b1);
    cs_fall = 1'b1; step();
    chk("R6 snap clear", irq_snap, 1'b0);
    cs_rise = 1'b1; step();

    // R11
    sw_in[10] = ~sw_in[10]; cs_fall = 1'b1; step();
    chk("R11 snap", irq_snap, 1'b1);
    chk("R11 irq", irq_pull_low, 1'b1);
    cs_rise = 1'b1; step();
    chk("R11 then release", irq_pull_low, 1'b0);

    // R8
    cs_fall = 1'b1; step();
    sw_in[0] = ~sw_in[0]; step();
    sw_in[0] = ~sw_in[0]; step();
    cs_rise = 1'b1; step();
    chk("R8 hold", irq_pull_low, 1'b1);
    xfer_clear();
    chk("R8 later release", irq_pull_low, 1'b0);

    // R9
    en_mask = ~(NSW'(1) << 7);
    cs_fall = 1'b1; step();
    sw_in[7] = ~sw_in[7]; step();
    cs_rise = 1'b1; step();
    chk("R9 masked no block", irq_pull_low, 1'b0);
    en_mask = '1;

    // R10
    sw_in[20] = ~sw_in[20]; step();
    chk("R10 pre", irq_pull_low, 1'b1);
    sleep = 1'b1; step();
    chk("R10 released", irq_pull_low, 1'b0);
    for (int k = 0; k < 4; k++) begin
      sw_in = sw_in ^ (NSW'(1) << (k * 5));
      step();
      chk("R10 asleep", irq_pull_low, 1'b0);
    end
    sleep = 1'b0; step(); step();
    chk("R10 wake quiet", irq_pull_low, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule